// File: doc/BRIEF.md
# Byte-Serial CRC-16 Frame Checker

This block validates received frames of a fixed byte count with the CCITT polynomial x^16 + x^12 + x^5 + 1. Bytes are offered one at a time with a strobe. Each accepted byte is folded into a 16-bit remainder one bit per clock, most significant bit first, so every byte takes eight clocks. While those clocks run, a busy flag is high. A strobe offered during busy is dropped and reported on a one-cycle overrun flag.

The last two bytes of a frame carry the ones' complement of the CRC taken over the preceding bytes, high byte first. When the final byte has been folded in, the remainder is compared with the fixed good residue. The block then raises exactly one verdict pulse, either pass or fail. A pass is accompanied, in the same cycle, by a transmit-command pulse that tells the surrounding reader to start its reply. A frame-start input discards any partial frame so that reception can begin cleanly.

Top module: `crc16_frame_checker`

## Requirements
- R1: The remainder starts at 0xFFFF after reset, after frame_clr and after every verdict. Each bit is shifted in MSB first with feedback polynomial 0x1021 and no final inversion.
- R2: A strobe seen while busy is low and frame_clr is low is accepted. busy is then high for exactly eight cycles, from the cycle after the accepting edge.
- R3: A strobe seen while busy is high is ignored and leaves the remainder untouched. overrun is high for one cycle after that edge.
- R4: After FRAME_BYTES accepted bytes, exactly one verdict pulse occurs. It is chk_pass if the remainder over all bytes equals 0x1D0F, and chk_fail otherwise. The frame format is data bytes followed by the inverted CRC, high byte first.
- R5: chk_pass and tx_cmd are high together for one cycle, after the ninth clock edge that follows the edge accepting the final byte.
- R6: chk_fail is a one-cycle pulse at the same point, with tx_cmd low. chk_pass and chk_fail are never high together.
- R7: frame_clr reloads the preset, clears the byte count and aborts a byte in progress, so busy is low in the next cycle. A strobe in the same cycle as frame_clr is neither accepted nor flagged.
- R8: After a verdict, the next accepted byte begins a new frame with no other action.
- R9: During reset and in the first cycles after it, busy, overrun, chk_pass, chk_fail and tx_cmd are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_clr | input | 1 | Start a new frame, discarding partial state |
| byte_vld | input | 1 | Byte strobe |
| byte_in | input | 8 | Received byte |
| busy | output | 1 | Byte being folded into the remainder |
| overrun | output | 1 | One-cycle flag: a strobe arrived during busy and was dropped |
| chk_pass | output | 1 | One-cycle pulse: frame residue matched |
| chk_fail | output | 1 | One-cycle pulse: frame residue did not match |
| tx_cmd | output | 1 | One-cycle pulse asking the reader to reply |

## Verification
Call the edge that accepts a byte E0. busy is due in the cycle after E0 and must drop after the eighth edge that follows E0. overrun is due in the cycle after the edge that saw the dropped strobe. The verdict and tx_cmd are due exactly nine edges after E0 of the final byte. The driver records the cycle count at E0 of each final byte and queues that count plus nine together with the expected verdict. The monitor samples on falling edges and compares both the verdict and its arrival cycle against the queue, so a pulse that comes early, late or without a queued entry fails.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY         = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET       = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_GOOD_RESIDUE = 16'h1D0F;

  // one MSB-first shift of the remainder with one incoming bit
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] rem,
                                                input logic din);
    logic fb;
    fb = rem[CRC_W-1] ^ din;
    return {rem[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/crc16_rst_sync.sv
module crc16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/crc16_bit_engine.sv
module crc16_bit_engine
  import crc16_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             restart,
  input  logic             byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  output logic             busy,
  output logic             collide,
  output logic             byte_done,
  output logic [CRC_W-1:0] remainder
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic              collide_q, collide_d;
  logic              done_q, done_d;
  logic              accept;
  logic              step_en, sreg_en, crc_en;

  assign accept  = byte_vld && !busy_q && !frame_clr;
  assign step_en = busy_q && !frame_clr;
  assign sreg_en = accept || step_en;
  assign crc_en  = frame_clr || restart || step_en;

  // next-state
  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    sreg_d    = sreg_q;
    crc_d     = crc_q;
    done_d    = 1'b0;
    collide_d = byte_vld && busy_q && !frame_clr;
    if (frame_clr) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      crc_d  = CRC_PRESET;
    end else begin
      if (restart) crc_d = CRC_PRESET;
      if (accept) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        sreg_d = byte_in;
      end else if (step_en) begin
        crc_d  = crc_step(crc_q, sreg_q[DATA_W-1]);
        sreg_d = {sreg_q[DATA_W-2:0], 1'b0};
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      sreg_q    <= '0;
      crc_q     <= CRC_PRESET;
      collide_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      collide_q <= collide_d;
      done_q    <= done_d;
      if (sreg_en) sreg_q <= sreg_d;
      if (crc_en)  crc_q  <= crc_d;
    end
  end

  assign busy      = busy_q;
  assign collide   = collide_q;
  assign byte_done = done_q;
  assign remainder = crc_q;

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !busy_q && !frame_clr) |=> busy_q);
  // R2
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(frame_clr)) |-> done_q);
  // R3
  collide_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide_q |-> $past(busy_q));
  // R7
  clr_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (crc_q == CRC_PRESET && !busy_q && !collide_q));
endmodule

// File: rtl/crc16_frame_seq.sv
module crc16_frame_seq
  import crc16_pkg::*;
#(
  parameter int FRAME_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             byte_done,
  input  logic [CRC_W-1:0] remainder,
  output logic             restart,
  output logic             chk_pass,
  output logic             chk_fail,
  output logic             tx_cmd
);
  localparam int CNT_W = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 2;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pass_q, pass_d;
  logic             fail_q, fail_d;
  logic             tx_q, tx_d;
  logic             last_byte;
  logic             residue_ok;

  assign last_byte  = byte_done && !frame_clr && (cnt_q == LAST_IDX);
  assign residue_ok = (remainder == CRC_GOOD_RESIDUE);
  assign restart    = last_byte;

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    pass_d = last_byte && residue_ok;
    fail_d = last_byte && !residue_ok;
    tx_d   = last_byte && residue_ok;
    if (frame_clr)      cnt_d = '0;
    else if (last_byte) cnt_d = '0;
    else if (byte_done) cnt_d = cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
      tx_q   <= tx_d;
    end
  end

  assign chk_pass = pass_q;
  assign chk_fail = fail_q;
  assign tx_cmd   = tx_q;

  // R4
  verdict_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q || fail_q) |-> $past(byte_done));
  // R5
  tx_with_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q |-> (pass_q && $past(remainder) == CRC_GOOD_RESIDUE));
  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_q, fail_q}));
  // R6
  fail_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> !tx_q);
  // R8
  new_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q || fail_q) |-> (cnt_q == '0));
endmodule

// File: rtl/crc16_frame_checker.sv
module crc16_frame_checker
  import crc16_pkg::*;
#(
  parameter int FRAME_BYTES = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_clr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  output logic              busy,
  output logic              overrun,
  output logic              chk_pass,
  output logic              chk_fail,
  output logic              tx_cmd
);
  logic             rst_n_int;
  logic             restart;
  logic             byte_done;
  logic [CRC_W-1:0] remainder;

  crc16_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  crc16_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .frame_clr (frame_clr),
    .restart   (restart),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .busy      (busy),
    .collide   (overrun),
    .byte_done (byte_done),
    .remainder (remainder)
  );

  crc16_frame_seq #(.FRAME_BYTES(FRAME_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .frame_clr (frame_clr),
    .byte_done (byte_done),
    .remainder (remainder),
    .restart   (restart),
    .chk_pass  (chk_pass),
    .chk_fail  (chk_fail),
    .tx_cmd    (tx_cmd)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> !(busy || overrun || chk_pass || chk_fail || tx_cmd));
endmodule

// File: tb/sim_crc16_frame_checker.sv
module sim_crc16_frame_checker;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clr = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       busy, overrun, chk_pass, chk_fail, tx_cmd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  typedef struct { bit pass; int due; } exp_t;
  exp_t exp_q[$];

  crc16_frame_checker #(.FRAME_BYTES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .byte_vld(byte_vld),
    .byte_in(byte_in), .busy(busy), .overrun(overrun), .chk_pass(chk_pass),
    .chk_fail(chk_fail), .tx_cmd(tx_cmd)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // reference CRC, written from R1
  function automatic logic [15:0] ref_crc(input logic [15:0] seed, input logic [7:0] b);
    logic [15:0] r = seed;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  // driver: one byte, optional intruder strobe at step k (1..8)
  task automatic send_byte(input logic [7:0] b, input bit push, input bit exp_pass,
                           input int intrude_at);
    int t0;
    @(negedge clk);
    byte_vld = 1'b1; byte_in = b;
    @(negedge clk);
    byte_vld = 1'b0;
    t0 = cyc;
    if (push) exp_q.push_back('{exp_pass, t0 + 9});
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    for (int i = 1; i <= 8; i++) begin
      if (intrude_at == i) begin
        byte_vld = 1'b1; byte_in = ~b;
        @(negedge clk);
        byte_vld = 1'b0;
        check(overrun == 1'b1, "R3 overrun flag", overrun, 1);
      end else begin
        @(negedge clk);
      end
    end
    check(busy == 1'b0, "R2 busy low after 8 steps", busy, 0);
  endtask

  // frame of N-2 data bytes + trailer; mode 0 inverted crc, 1 plain crc, 2 flip data bit
  task automatic send_frame(input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input logic [7:0] d3,
                            input int mode, input int intrude_at);
    logic [7:0]  fr [N];
    logic [15:0] c;
    logic [15:0] res;
    fr[0] = d0; fr[1] = d1; fr[2] = d2; fr[3] = d3;
    c = 16'hFFFF;
    for (int i = 0; i < N-2; i++) c = ref_crc(c, fr[i]);
    if (mode == 1) begin fr[N-2] = c[15:8];  fr[N-1] = c[7:0]; end
    else           begin fr[N-2] = ~c[15:8]; fr[N-1] = ~c[7:0]; end
    if (mode == 2) fr[1] = fr[1] ^ 8'h10;
    res = 16'hFFFF;
    for (int i = 0; i < N; i++) res = ref_crc(res, fr[i]);
    for (int i = 0; i < N; i++)
      send_byte(fr[i], i == N-1, res == 16'h1D0F, (i == 2) ? intrude_at : 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (tx_cmd && !chk_pass) check(1'b0, "R5 tx_cmd without pass", 1, 0);
      if (chk_pass || chk_fail) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected verdict", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(chk_pass == e.pass, "R4 verdict", chk_pass, e.pass);
          check(cyc == e.due, "R5 verdict cycle", cyc, e.due);
          check(tx_cmd == e.pass, e.pass ? "R5 tx_cmd with pass" : "R6 no tx_cmd on fail",
                tx_cmd, e.pass);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, overrun, chk_pass, chk_fail, tx_cmd} == 5'b0, "R9 outputs in reset",
          {busy, overrun, chk_pass, chk_fail, tx_cmd}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, overrun, chk_pass, chk_fail, tx_cmd} == 5'b0, "R9 outputs after reset",
          {busy, overrun, chk_pass, chk_fail, tx_cmd}, 0);

    // R1 R4 R5 good frames, different data patterns
    send_frame(8'h12, 8'h34, 8'h56, 8'h78, 0, 0);
    send_frame(8'h00, 8'h00, 8'h00, 8'h00, 0, 0);
    send_frame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 0, 0);
    // R6 corrupted data and non-inverted trailer
    send_frame(8'hA5, 8'h5A, 8'hC3, 8'h3C, 2, 0);
    send_frame(8'hA5, 8'h5A, 8'hC3, 8'h3C, 1, 0);
    // R3 intruder strobes at several steps must not disturb the result
    send_frame(8'hDE, 8'hAD, 8'hBE, 8'hEF, 0, 3);
    send_frame(8'h01, 8'h80, 8'h7F, 8'hFE, 0, 8);

    // R7 partial frame discarded by frame_clr
    send_byte(8'h11, 0, 0, 0);
    send_byte(8'h22, 0, 0, 0);
    send_byte(8'h33, 0, 0, 0);
    @(negedge clk); frame_clr = 1'b1;
    @(negedge clk); frame_clr = 1'b0;
    send_frame(8'h12, 8'h34, 8'h56, 8'h78, 0, 0);

    // R7 abort mid-byte
    @(negedge clk); byte_vld = 1'b1; byte_in = 8'h99;
    @(negedge clk); byte_vld = 1'b0;
    repeat (3) @(negedge clk);
    frame_clr = 1'b1;
    @(negedge clk); frame_clr = 1'b0;
    check(busy == 1'b0, "R7 abort clears busy", busy, 0);

    // R7 strobe coincident with frame_clr is dropped silently
    frame_clr = 1'b1; byte_vld = 1'b1; byte_in = 8'h44;
    @(negedge clk); frame_clr = 1'b0; byte_vld = 1'b0;
    check(busy == 1'b0, "R7 strobe with clear not accepted", busy, 0);
    check(overrun == 1'b0, "R7 strobe with clear not flagged", overrun, 0);
    send_frame(8'h0F, 8'hF0, 8'h55, 8'hAA, 0, 0);

    // R8 back-to-back frames without clear
    send_frame(8'h31, 8'h32, 8'h33, 8'h34, 0, 0);
    send_frame(8'h31, 8'h32, 8'h33, 8'h35, 2, 0);
    send_frame(8'h41, 8'h42, 8'h43, 8'h44, 0, 0);

    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R4 all verdicts seen", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule